// File: doc/BRIEF.md
# Line Wake-Up Pulse Detector

This block watches a bidirectional communication line that the local driver may be forcing high or low, and recognises a wake-up request: some other party pulls the line against the level the local driver is putting on it, and keeps it there for a qualification time. Whether a mismatch counts as a forced line depends on how the driver is configured. A push-pull driver can be overridden in either direction. A high-side driver can only be pulled low. A low-side driver can only be pulled high. A driver that is switched off cannot be overridden at all. All timing is counted in ticks of a one-cycle microsecond strobe.

When a request qualifies, the block produces an active-low wake-up pulse of fixed length. If interrupts are enabled, it also sets a sticky wake-up flag and raises its IRQ contribution. The flag is set when the line is let go, not when the request qualifies. A status-register read strobe clears the flag. Each unbroken forced period reports at most one wake-up.

The qualification machine has three states. IDLE means no forced line is present. QUALIFY means a forced line is present and its ticks are being counted. LATCHED means a wake-up was reported and the block is waiting for the line to be let go. Its transitions are as follows:
- IDLE to QUALIFY when a forced line is first seen.
- IDLE to LATCHED directly, only when the qualification time is a single tick.
- QUALIFY to IDLE when the forced line ends early.
- QUALIFY to LATCHED when the tick count completes.
- LATCHED to IDLE when the line is let go, which raises the release event.

The pulse generator has two states, PULSE_IDLE and PULSE_LOW. A detection moves it from PULSE_IDLE to PULSE_LOW, or restarts it if it is already in PULSE_LOW. It returns from PULSE_LOW to PULSE_IDLE after the last tick of the pulse.

Top module: `wake_detect`

## Requirements
- R1: In push-pull mode (`drv_mode` = 2'b01), a sensed level that differs from the driven level counts as a forced line in either direction.
- R2: In high-side mode (2'b10), only a line sensed low while driven high counts as forced. In low-side mode (2'b11), only a line sensed high while driven low counts. In off mode (2'b00), nothing counts as forced and no pulse is produced.
- R3: A wake-up is detected on the QUAL_US-th tick (default 80) sampled while the line is continuously forced. `wake_n` goes low at that clock edge. A forced period that ends earlier produces no pulse, and a later forced period starts counting from zero.
- R4: On detection, `wake_n` stays low for exactly PULSE_US ticks (default 190), counting the detecting tick as the first, and then returns high.
- R5: One continuous forced period yields exactly one pulse, however long it lasts. A new detection requires the line to be let go first.
- R6: With `wake_irq_en` high, `wake_flag` stays low while the line is held after detection. It goes high at the clock edge where the line is first seen let go.
- R7: With `wake_irq_en` low at the moment of release, `wake_flag` is not set.
- R8: A one-cycle `status_rd` clears `wake_flag` at the next edge. If a release sets the flag in the same cycle, setting wins.
- R9: `irq_req` is high exactly when `wake_flag` is high.
- R10: After reset, `wake_n` is high and `wake_flag` and `irq_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| drv_mode | input | 2 | Driver mode: 00 off, 01 push-pull, 10 high-side, 11 low-side |
| drv_level | input | 1 | Level the local driver is applying |
| line_level | input | 1 | Level sensed on the line |
| wake_irq_en | input | 1 | Enables the wake-up flag on release |
| status_rd | input | 1 | Status-register read strobe, clears the flag |
| wake_n | output | 1 | Active-low wake-up pulse |
| wake_flag | output | 1 | Sticky wake-up interrupt bit |
| irq_req | output | 1 | IRQ contribution of this block |

## Verification
Some properties are checked by the assertions on every cycle:
- Off mode never reports a forced line.
- The qualification and pulse counters stay within their limits.
- A detection drives `wake_n` low on the next cycle.
- A held line keeps the machine latched.
- A rising flag always traces back to an enabled release.
- A set and a read in the same cycle leave the flag set.

Other behaviour can only be shown by the bench scenarios:
- The exact tick at which qualification completes, including the 79-versus-80 boundary and a count that restarts after an interrupted short.
- The exact 190-tick pulse length.
- The one-pulse-per-short rule across a 400-tick hold.
- The per-mode direction rules.

// File: rtl/wake_pkg.sv
package wake_pkg;

    typedef enum logic [1:0] {
        MODE_OFF       = 2'b00,
        MODE_PUSH_PULL = 2'b01,
        MODE_HIGH_SIDE = 2'b10,
        MODE_LOW_SIDE  = 2'b11
    } drv_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_QUALIFY = 2'b01,
        ST_LATCHED = 2'b10
    } qual_state_e;

    typedef enum logic {
        PULSE_IDLE = 1'b0,
        PULSE_LOW  = 1'b1
    } pulse_state_e;

endpackage

// File: rtl/wake_short_sense.sv
module wake_short_sense
    import wake_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  drv_mode_e mode,
    input  logic      drv_level,
    input  logic      line_level,
    output logic      short_now
);

    always_comb begin
        short_now = 1'b0;
        unique case (mode)
            MODE_OFF:       short_now = 1'b0;
            MODE_PUSH_PULL: short_now = (line_level != drv_level);
            MODE_HIGH_SIDE: short_now = drv_level && !line_level;
            MODE_LOW_SIDE:  short_now = !drv_level && line_level;
            default:        short_now = 1'b0;
        endcase
    end

    // R2: an undriven line never reports a forced condition
    assert_off_never_short_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |-> !short_now);

endmodule

// File: rtl/wake_qual_fsm.sv
module wake_qual_fsm
    import wake_pkg::*;
#(
    parameter int QUAL_US = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic short_now,
    output logic det_evt,
    output logic rel_evt
);

    localparam int QCW = $clog2(QUAL_US + 1);
    localparam logic [QCW-1:0] QLAST = QCW'(QUAL_US - 1);

    qual_state_e     state_q, state_d;
    logic [QCW-1:0]  cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        det_evt = 1'b0;
        rel_evt = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (short_now) begin
                    if (us_tick && (QLAST == '0)) begin
                        state_d = ST_LATCHED;
                        det_evt = 1'b1;
                    end else begin
                        state_d = ST_QUALIFY;
                        cnt_d   = us_tick ? QCW'(1) : '0;
                    end
                end
            end
            ST_QUALIFY: begin
                if (!short_now) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (us_tick) begin
                    if (cnt_q == QLAST) begin
                        state_d = ST_LATCHED;
                        cnt_d   = '0;
                        det_evt = 1'b1;
                    end else begin
                        cnt_d = cnt_q + QCW'(1);
                    end
                end
            end
            ST_LATCHED: begin
                cnt_d = '0;
                if (!short_now) begin
                    state_d = ST_IDLE;
                    rel_evt = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // R3: qualification count never reaches the limit
    assert_qual_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < QCW'(QUAL_US));

    // R5: a held line keeps the machine latched, so no second detection
    assert_latched_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCHED && short_now) |=> (state_q == ST_LATCHED));

    // R6: release event always returns the machine to idle
    assert_release_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rel_evt |=> (state_q == ST_IDLE));

endmodule

// File: rtl/wake_pulse_gen.sv
module wake_pulse_gen
    import wake_pkg::*;
#(
    parameter int PULSE_US = 190
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic det_evt,
    output logic wake_n
);

    localparam int PCW = $clog2(PULSE_US + 1);
    localparam logic [PCW-1:0] PLAST = PCW'(PULSE_US - 1);

    pulse_state_e   pst_q, pst_d;
    logic [PCW-1:0] pcnt_q, pcnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pst_q  <= PULSE_IDLE;
            pcnt_q <= '0;
        end else begin
            pst_q  <= pst_d;
            pcnt_q <= pcnt_d;
        end
    end

    always_comb begin
        pst_d  = pst_q;
        pcnt_d = pcnt_q;
        if (det_evt) begin
            pst_d  = PULSE_LOW;
            pcnt_d = '0;
        end else begin
            unique case (pst_q)
                PULSE_IDLE: pcnt_d = '0;
                PULSE_LOW: begin
                    if (us_tick) begin
                        if (pcnt_q == PLAST) begin
                            pst_d  = PULSE_IDLE;
                            pcnt_d = '0;
                        end else begin
                            pcnt_d = pcnt_q + PCW'(1);
                        end
                    end
                end
                default: pst_d = PULSE_IDLE;
            endcase
        end
    end

    assign wake_n = (pst_q != PULSE_LOW);

    // R4: a detection starts the low pulse on the next cycle
    assert_pulse_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        det_evt |=> !wake_n);

    // R4: the pulse tick counter stays inside the pulse length
    assert_pulse_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q < PCW'(PULSE_US));

endmodule

// File: rtl/wake_irq_latch.sv
module wake_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic rel_evt,
    input  logic irq_en,
    input  logic status_rd,
    output logic flag
);

    logic set_now;
    assign set_now = rel_evt && irq_en;

    always_ff @(posedge clk) begin
        if (!rst_n)          flag <= 1'b0;
        else if (set_now)    flag <= 1'b1;
        else if (status_rd)  flag <= 1'b0;
    end

    // R6: the flag only rises after an enabled release
    assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(rel_evt && irq_en));

    // R8: set wins over a simultaneous read
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_evt && irq_en && status_rd) |=> flag);

    // R8: a read without a simultaneous set clears the flag
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !(rel_evt && irq_en)) |=> !flag);

endmodule

// File: rtl/wake_detect.sv
module wake_detect
    import wake_pkg::*;
#(
    parameter int QUAL_US  = 80,
    parameter int PULSE_US = 190
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic [1:0] drv_mode,
    input  logic       drv_level,
    input  logic       line_level,
    input  logic       wake_irq_en,
    input  logic       status_rd,
    output logic       wake_n,
    output logic       wake_flag,
    output logic       irq_req
);

    logic short_now;
    logic det_evt;
    logic rel_evt;

    wake_short_sense u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (drv_mode_e'(drv_mode)),
        .drv_level  (drv_level),
        .line_level (line_level),
        .short_now  (short_now)
    );

    wake_qual_fsm #(.QUAL_US(QUAL_US)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .short_now (short_now),
        .det_evt   (det_evt),
        .rel_evt   (rel_evt)
    );

    wake_pulse_gen #(.PULSE_US(PULSE_US)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_tick (us_tick),
        .det_evt (det_evt),
        .wake_n  (wake_n)
    );

    wake_irq_latch u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .rel_evt   (rel_evt),
        .irq_en    (wake_irq_en),
        .status_rd (status_rd),
        .flag      (wake_flag)
    );

    assign irq_req = wake_flag;

    // R9: the IRQ contribution never rises without the flag having been set by a release
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(rel_evt && wake_irq_en));

endmodule

// File: tb/wake_detect_tb_top.sv
`timescale 1ns/1ps
module wake_detect_tb_top;

    localparam int QUAL_US  = 80;
    localparam int PULSE_US = 190;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic [1:0] drv_mode = 2'b00;
    logic       drv_level = 1'b0;
    logic       line_level = 1'b0;
    logic       wake_irq_en = 1'b0;
    logic       status_rd = 1'b0;
    logic       wake_n;
    logic       wake_flag;
    logic       irq_req;

    int checks = 0;
    int errors = 0;
    int exp_q[$];

    always #2.5 clk = ~clk;

    wake_detect #(.QUAL_US(QUAL_US), .PULSE_US(PULSE_US)) dut_i (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .drv_mode(drv_mode),
        .drv_level(drv_level), .line_level(line_level), .wake_irq_en(wake_irq_en),
        .status_rd(status_rd), .wake_n(wake_n), .wake_flag(wake_flag), .irq_req(irq_req)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) us_tick = 1'b1;
            @(negedge clk) us_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    // Driver: apply a level pair for n ticks; push an expected pulse length if one is due
    task automatic hold_line(input logic [1:0] mode, input logic dl, input logic ll,
                             input int n, input bit expect_low, input string req);
        @(negedge clk);
        drv_mode   = mode;
        drv_level  = dl;
        line_level = ll;
        tick_n(n);
        check(wake_n == !expect_low, req, "wake_n after hold", wake_n, !expect_low);
        if (expect_low) exp_q.push_back(PULSE_US);
    endtask

    task automatic release_line();
        @(negedge clk) line_level = drv_level;
        @(negedge clk);
    endtask

    task automatic read_status();
        @(negedge clk) status_rd = 1'b1;
        @(negedge clk) status_rd = 1'b0;
    endtask

    // Monitor: measure each low pulse in ticks and compare with the scoreboard
    int  pulse_len = 0;
    bit  prev_low  = 1'b0;
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (!wake_n && us_tick) pulse_len++;
            if (prev_low && wake_n) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected pulse", pulse_len, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(pulse_len == e, "R4", "pulse length in ticks", pulse_len, e);
                end
                pulse_len = 0;
            end
            prev_low = !wake_n;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check(wake_n == 1'b1, "R10", "reset wake_n", wake_n, 1);
        check(wake_flag == 1'b0, "R10", "reset wake_flag", wake_flag, 0);
        check(irq_req == 1'b0, "R10", "reset irq_req", irq_req, 0);
        @(negedge clk) rst_n = 1'b1;
        wake_irq_en = 1'b1;

        // R3: one tick short of qualification
        hold_line(2'b01, 1'b1, 1'b0, QUAL_US - 1, 1'b0, "R3");
        release_line();
        tick_n(10);
        check(wake_flag == 1'b0, "R3", "no flag without detection", wake_flag, 0);

        // R1: push-pull, forced low
        hold_line(2'b01, 1'b1, 1'b0, QUAL_US, 1'b1, "R1");
        check(wake_flag == 1'b0, "R6", "flag low while held", wake_flag, 0);
        release_line();
        check(wake_flag == 1'b1, "R6", "flag set at release", wake_flag, 1);
        check(irq_req == 1'b1, "R9", "irq with flag", irq_req, 1);
        tick_n(200);
        read_status();
        check(wake_flag == 1'b0, "R8", "read clears flag", wake_flag, 0);
        check(irq_req == 1'b0, "R9", "irq follows clear", irq_req, 0);

        // R1: push-pull, forced high
        hold_line(2'b01, 1'b0, 1'b1, QUAL_US, 1'b1, "R1");
        release_line();
        tick_n(200);
        read_status();

        // R2: high-side, valid and invalid directions
        hold_line(2'b10, 1'b1, 1'b0, QUAL_US, 1'b1, "R2");
        release_line();
        tick_n(200);
        read_status();
        hold_line(2'b10, 1'b0, 1'b1, 120, 1'b0, "R2");
        release_line();
        check(wake_flag == 1'b0, "R2", "high-side pulled high ignored", wake_flag, 0);

        // R2: low-side, valid and invalid directions
        hold_line(2'b11, 1'b0, 1'b1, QUAL_US, 1'b1, "R2");
        release_line();
        tick_n(200);
        read_status();
        hold_line(2'b11, 1'b1, 1'b0, 120, 1'b0, "R2");
        release_line();
        check(wake_flag == 1'b0, "R2", "low-side pulled low ignored", wake_flag, 0);

        // R2: off mode
        hold_line(2'b00, 1'b1, 1'b0, 120, 1'b0, "R2");
        release_line();
        check(wake_flag == 1'b0, "R2", "off mode ignored", wake_flag, 0);

        // R3: interrupted short restarts the count
        hold_line(2'b01, 1'b1, 1'b0, 50, 1'b0, "R3");
        release_line();
        hold_line(2'b01, 1'b1, 1'b0, 50, 1'b0, "R3");
        tick_n(QUAL_US - 50);
        check(wake_n == 1'b0, "R3", "restarted count completes", wake_n, 0);
        exp_q.push_back(PULSE_US);
        release_line();
        tick_n(200);
        read_status();

        // R5: long hold gives one pulse only
        hold_line(2'b01, 1'b1, 1'b0, QUAL_US, 1'b1, "R5");
        tick_n(320);
        check(wake_n == 1'b1, "R5", "no second pulse during hold", wake_n, 1);
        release_line();
        tick_n(200);
        read_status();

        // R7: interrupt disabled
        wake_irq_en = 1'b0;
        hold_line(2'b01, 1'b1, 1'b0, QUAL_US, 1'b1, "R7");
        release_line();
        check(wake_flag == 1'b0, "R7", "flag stays low when disabled", wake_flag, 0);
        tick_n(200);

        // R8: release and read in the same cycle, set wins
        wake_irq_en = 1'b1;
        hold_line(2'b01, 1'b1, 1'b0, QUAL_US, 1'b1, "R8");
        @(negedge clk);
        line_level = drv_level;
        status_rd  = 1'b1;
        @(negedge clk) status_rd = 1'b0;
        check(wake_flag == 1'b1, "R8", "set wins over read", wake_flag, 1);
        tick_n(200);
        read_status();
        check(wake_flag == 1'b0, "R8", "later read clears", wake_flag, 0);

        check(exp_q.size() == 0, "R4", "all expected pulses seen", exp_q.size(), 0);
        finish_run();
    end

endmodule